// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status-Tagged Character Queue

This block recovers characters from an asynchronous serial line that is sampled by the system clock and paced by a one-cycle enable at sixteen times the bit rate. A start bit is validated at its centre. Data bits arrive least significant first and are sampled once per bit period in the middle of the bit. The block then checks the optional parity bit and one or two stop bits. Each finished character is placed in a 32-deep queue together with its own error tags, so the status of a character stays with it until the character is read.

The consumer sees the head of the queue as one 16-bit word. It advances the queue with a single-cycle pop. A data-ready level, a threshold interrupt with a programmable level and a sticky break indication complete the interface. The word size, parity and stop bits come from static control inputs, and a receive enable gates capture.

Top module: `urx_tagged_rx`

## Requirements
- R1: A falling edge on the line begins a start-bit check. The start bit is accepted only if the line is still low 8 ticks later, so a low pulse shorter than that produces no character. After an accepted start bit, each data bit is sampled every 16 ticks, least significant bit first.
- R2: `word8`=1 receives 8 data bits and `word8`=0 receives 7 bits, with bit 7 of the stored character forced to 0. `par_en`=1 adds a parity bit after the data, which is even when `par_odd`=0 and odd when `par_odd`=1. `two_stop`=1 expects two stop bits.
- R3: A character whose parity bit does not match the selected sense is stored with bit 10 (parity) and bit 14 (any error) of the read word set.
- R4: A character whose stop bit (either stop bit, in two-stop mode) samples low is stored with bits 12 and 14 set. After such a frame, the receiver waits for the line to return high before it looks for a new start bit.
- R5: A frame in which all data bits, the parity bit (if enabled) and the first stop bit sample low is a break. It is stored as character 0x00 with bits 11, 12 and 14 set and bit 10 clear. A break also sets `brk_flag`, which stays high until a one-cycle pulse on `brk_clr`; a break arriving in the same cycle as the clear pulse wins.
- R6: The queue holds 32 characters, which are read in arrival order. While the queue is not empty, `rd_word` shows the head entry with bit 15 = 1, tags in bits 14:10, bits 9:8 = 0 and the character in bits 7:0. When the queue is empty, `rd_word` is 0. A pulse on `rd_pop` removes the head entry, and a pop on an empty queue is ignored.
- R7: A character that completes while the queue is full is discarded. The next character that is stored then carries bit 13 (overrun) and bit 14.
- R8: `data_rdy` is high exactly while at least one unread character is in the queue.
- R9: `rrdy_irq` is high when `rrdy_ie`=1 and the queue holds at least `trig_lvl` characters. A `trig_lvl` of 0 acts as 1.
- R10: While `rx_en`=0, no character enters the queue, and a frame in progress is abandoned.
- R11: After reset the queue is empty, `rd_word` is 0, and `data_rdy`, `rrdy_irq` and `brk_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idles high |
| rx_en | input | 1 | Receive enable |
| word8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| trig_lvl | input | 6 | Interrupt occupancy threshold |
| rrdy_ie | input | 1 | Threshold interrupt enable |
| rd_pop | input | 1 | Remove the head entry |
| brk_clr | input | 1 | Clear the sticky break flag |
| rd_word | output | 16 | Head entry: valid, tags and character |
| data_rdy | output | 1 | Queue not empty |
| rrdy_irq | output | 1 | Threshold interrupt |
| brk_flag | output | 1 | Sticky break indication |

## Verification
The receiver is driven with clean frames in every combination of word size, parity sense and stop count. Comparing the stored character against the sent one shows whether bit order, bit count and sampling phase are correct. Frames with a flipped parity bit or a low stop bit check that each fault sets only its own tag. An all-low frame checks that a break is told apart from a simple framing error, and the frame that follows it shows that the receiver recovers. A short low glitch, a disabled receiver and a 33rd character into a full queue each test that a frame is rejected. The overrun tag on the next stored character confirms that the discard was remembered.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef struct packed {
    logic       ovr;
    logic       ferr;
    logic       brk;
    logic       perr;
    logic [7:0] data;
  } urx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP1,
    S_STOP2,
    S_WAITHI
  } urx_state_e;

  localparam int unsigned ENTRY_W = $bits(urx_entry_t);

endpackage

// File: rtl/urx_deser.sv
module urx_deser
  import urx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       enable,
  input  logic       word8,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  output logic       frm_valid,
  output urx_entry_t frm
);

  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);

  urx_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bidx_q, bidx_d;
  logic [7:0]    shf_q, shf_d;
  logic          par_q, par_d;
  logic          s1low_q, s1low_d;
  logic          valid_q, valid_d;
  urx_entry_t    frm_q, frm_d;

  logic          fin;
  logic          fin_s1low;
  logic          fin_anylow;
  logic [7:0]    data_raw;
  logic          is_brk;
  logic [2:0]    last_idx;

  assign last_idx = word8 ? 3'd7 : 3'd6;
  assign data_raw = word8 ? shf_q : {1'b0, shf_q[7:1]};
  assign is_brk   = (data_raw == 8'h00) && (!par_en || !par_q) && fin_s1low;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    bidx_d     = bidx_q;
    shf_d      = shf_q;
    par_d      = par_q;
    s1low_d    = s1low_q;
    valid_d    = 1'b0;
    frm_d      = frm_q;
    fin        = 1'b0;
    fin_s1low  = 1'b0;
    fin_anylow = 1'b0;
    if (!enable) begin
      state_d = S_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      case (state_q)
        S_IDLE: begin
          if (!rxd) begin
            state_d = S_START;
            cnt_d   = '0;
          end
        end
        S_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d  = '0;
            bidx_d = '0;
            state_d = rxd ? S_IDLE : S_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d  = '0;
            shf_d  = {rxd, shf_q[7:1]};
            bidx_d = bidx_q + 1'b1;
            if (bidx_q == last_idx) begin
              state_d = par_en ? S_PAR : S_STOP1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_PAR: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            par_d   = rxd;
            state_d = S_STOP1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_STOP1: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d   = '0;
            s1low_d = !rxd;
            if (two_stop) begin
              state_d = S_STOP2;
            end else begin
              fin        = 1'b1;
              fin_s1low  = !rxd;
              fin_anylow = !rxd;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_STOP2: begin
          if (cnt_q == LAST_CNT) begin
            cnt_d      = '0;
            fin        = 1'b1;
            fin_s1low  = s1low_q;
            fin_anylow = s1low_q | !rxd;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_WAITHI: begin
          if (rxd) state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
      if (fin) begin
        valid_d    = 1'b1;
        frm_d.ovr  = 1'b0;
        frm_d.ferr = fin_anylow;
        frm_d.brk  = is_brk;
        frm_d.perr = par_en && !is_brk && (^data_raw ^ par_q ^ par_odd);
        frm_d.data = is_brk ? 8'h00 : data_raw;
        state_d    = fin_anylow ? S_WAITHI : S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      shf_q   <= '0;
      par_q   <= 1'b0;
      s1low_q <= 1'b0;
      valid_q <= 1'b0;
      frm_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bidx_q  <= bidx_d;
      shf_q   <= shf_d;
      par_q   <= par_d;
      s1low_q <= s1low_d;
      valid_q <= valid_d;
      frm_q   <= frm_d;
    end
  end

  assign frm_valid = valid_q;
  assign frm       = frm_q;

  // R1: a finished frame is reported for exactly one cycle
  p_one_shot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);

  // R5: a break is always also a framing fault with a zero character
  p_brk_framing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm.brk) |-> (frm.ferr && frm.data == 8'h00 && !frm.perr));

  // R10: a disabled receiver parks in idle
  p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state_q == S_IDLE && !frm_valid));

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 12,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    wdata,
  input  logic            pop,
  output logic [W-1:0]    rdata,
  output logic [CNTW-1:0] count
);

  logic [W-1:0]    mem_q [DEPTH];
  logic [AW-1:0]   wptr_q, wptr_d;
  logic [AW-1:0]   rptr_q, rptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            do_push;
  logic            do_pop;

  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && ((cnt_q != CNTW'(DEPTH)) || do_pop);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) begin
      wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    end
    if (do_pop) begin
      rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wptr_q] <= wdata;
    end
  end

  assign rdata = mem_q[rptr_q];
  assign count = cnt_q;

  // R6: occupancy never exceeds the queue depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));

  // R6: occupancy moves by at most one entry per cycle
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1) ||
    (count == $past(count) - 1'b1));

  // R6: a pop on an empty queue leaves it empty
  p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count == '0) |=> (count == '0));

endmodule

// File: rtl/urx_tagged_rx.sv
module urx_tagged_rx
  import urx_pkg::*;
#(
  parameter int unsigned DEPTH       = 32,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TRIG_W      = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              word8,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic [TRIG_W-1:0] trig_lvl,
  input  logic              rrdy_ie,
  input  logic              rd_pop,
  input  logic              brk_clr,
  output logic [15:0]       rd_word,
  output logic              data_rdy,
  output logic              rrdy_irq,
  output logic              brk_flag
);

  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam int unsigned CMPW = (CNTW > TRIG_W) ? CNTW : TRIG_W;

  logic            rxd_s;
  logic            frm_valid;
  urx_entry_t      frm;
  urx_entry_t      entry_in;
  urx_entry_t      head;
  logic [CNTW-1:0] count;
  logic            q_full;
  logic            pop_eff;
  logic            accept;
  logic            push;
  logic            ovr_pend_q, ovr_pend_d;
  logic            brk_q, brk_d;
  logic [CMPW-1:0] thr_ext;
  logic [CMPW-1:0] cnt_ext;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rxd_s = rxd;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '1;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
        end
      end
      assign rxd_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  urx_deser #(.OVS(OVS)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .rxd       (rxd_s),
    .enable    (rx_en),
    .word8     (word8),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .two_stop  (two_stop),
    .frm_valid (frm_valid),
    .frm       (frm)
  );

  assign q_full  = (count == CNTW'(DEPTH));
  assign pop_eff = rd_pop && (count != '0);
  assign accept  = !q_full || pop_eff;
  assign push    = frm_valid && rx_en && accept;

  always_comb begin
    entry_in     = frm;
    entry_in.ovr = ovr_pend_q;
  end

  urx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (entry_in),
    .pop   (rd_pop),
    .rdata (head),
    .count (count)
  );

  always_comb begin
    ovr_pend_d = ovr_pend_q;
    brk_d      = brk_q;
    if (frm_valid && rx_en) begin
      ovr_pend_d = !accept;
    end
    if (brk_clr) begin
      brk_d = 1'b0;
    end
    if (frm_valid && rx_en && frm.brk) begin
      brk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_pend_q <= 1'b0;
      brk_q      <= 1'b0;
    end else begin
      ovr_pend_q <= ovr_pend_d;
      brk_q      <= brk_d;
    end
  end

  always_comb begin
    if (count == '0) begin
      rd_word = 16'h0000;
    end else begin
      rd_word = {1'b1, (head.ovr | head.ferr | head.brk | head.perr),
                 head.ovr, head.ferr, head.brk, head.perr, 2'b00, head.data};
    end
  end

  assign thr_ext  = (trig_lvl == '0) ? CMPW'(1) : CMPW'(trig_lvl);
  assign cnt_ext  = CMPW'(count);
  assign data_rdy = (count != '0);
  assign rrdy_irq = rrdy_ie && (cnt_ext >= thr_ext);
  assign brk_flag = brk_q;

  // R9: the threshold interrupt never fires on an empty queue
  p_irq_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rrdy_irq |-> data_rdy);

  // R5: the break flag holds until cleared
  p_brk_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(brk_flag) && !$past(brk_clr)) |-> brk_flag);

  // R10: with reception off the queue cannot grow
  p_rx_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (count <= $past(count)));

  // R6: an empty queue reads as all zeros
  p_empty_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rdy |-> (rd_word == 16'h0000));

endmodule

// File: tb/urx_tagged_rx_test.sv
`timescale 1ns/1ps
module urx_tagged_rx_test;

  localparam int DEPTH = 32;
  localparam int BITCLK = 64;

  logic        clk;
  logic        rst_n;
  logic        tick16;
  logic        rxd;
  logic        rx_en;
  logic        word8;
  logic        par_en;
  logic        par_odd;
  logic        two_stop;
  logic [5:0]  trig_lvl;
  logic        rrdy_ie;
  logic        rd_pop;
  logic        brk_clr;
  logic [15:0] rd_word;
  logic        data_rdy;
  logic        rrdy_irq;
  logic        brk_flag;

  int n_chk;
  int n_fail;
  bit finished;

  logic [15:0] expq[$];
  bit          m_pend;
  bit          m_brk;

  urx_tagged_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
    .word8(word8), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .trig_lvl(trig_lvl), .rrdy_ie(rrdy_ie), .rd_pop(rd_pop), .brk_clr(brk_clr),
    .rd_word(rd_word), .data_rdy(data_rdy), .rrdy_irq(rrdy_irq), .brk_flag(brk_flag)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    tick16 = 1'b0;
    for (int i = 0; ; i++) begin
      @(negedge clk);
      tick16 = ((i % 4) == 3);
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_word(logic [7:0] d, bit ov, bit fe, bit bk, bit pe);
    return {1'b1, (ov | fe | bk | pe), ov, fe, bk, pe, 2'b00, d};
  endfunction

  task automatic hold(input logic v);
    rxd = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [7:0]  dm;
    int          nb;
    logic        pbit;
    bit          bk;
    bit          pe;
    logic [15:0] w;
    nb   = word8 ? 8 : 7;
    dm   = word8 ? d : {1'b0, d[6:0]};
    pbit = (^dm) ^ par_odd ^ bad_par;
    hold(1'b0);
    for (int i = 0; i < nb; i++) hold(dm[i]);
    if (par_en) hold(pbit);
    hold(!bad_stop);
    if (two_stop) hold(1'b1);
    rxd = 1'b1;
    repeat (32) @(negedge clk);
    if (rx_en) begin
      bk = bad_stop && (dm == 8'h00) && (!par_en || pbit == 1'b0);
      pe = par_en && bad_par && !bk;
      if (expq.size() == DEPTH) begin
        m_pend = 1'b1;
      end else begin
        w = mk_word(bk ? 8'h00 : dm, m_pend, bad_stop, bk, pe);
        expq.push_back(w);
        m_pend = 1'b0;
      end
      if (bk) m_brk = 1'b1;
    end
  endtask

  task automatic pop_check(input string req);
    logic [15:0] e;
    e = expq.pop_front();
    chk(req, "data_rdy before pop", {31'b0, data_rdy}, 32'd1);
    chk(req, "head word", {16'b0, rd_word}, {16'b0, e});
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (expq.size() > 0) pop_check(req);
    chk(req, "empty after drain", {31'b0, data_rdy}, 32'd0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    n_chk = 0; n_fail = 0; finished = 0;
    m_pend = 0; m_brk = 0;
    rst_n = 1'b0; rxd = 1'b1; rx_en = 1'b1; word8 = 1'b1; par_en = 1'b0;
    par_odd = 1'b0; two_stop = 1'b0; trig_lvl = 6'd1; rrdy_ie = 1'b0;
    rd_pop = 1'b0; brk_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: reset state
    chk("R11", "rd_word", {16'b0, rd_word}, 32'h0);
    chk("R11", "data_rdy", {31'b0, data_rdy}, 0);
    chk("R11", "rrdy_irq", {31'b0, rrdy_irq}, 0);
    chk("R11", "brk_flag", {31'b0, brk_flag}, 0);

    // R1 R6: plain 8N1 character
    send_frame(8'hA5, 0, 0);
    chk("R8", "data_rdy one entry", {31'b0, data_rdy}, 1);
    chk("R1", "8N1 word", {16'b0, rd_word}, 32'h80A5);
    drain("R6");

    // R1: short glitch is rejected
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    chk("R1", "glitch ignored", {31'b0, data_rdy}, 0);

    // R2: 7 bits, even parity, two stops
    word8 = 0; par_en = 1; par_odd = 0; two_stop = 1;
    send_frame(8'hDA, 0, 0);
    chk("R2", "7E2 word", {16'b0, rd_word}, 32'h805A);
    drain("R2");
    // R2: 8 bits odd parity
    word8 = 1; par_odd = 1; two_stop = 0;
    send_frame(8'h3C, 0, 0);
    chk("R2", "8O1 word", {16'b0, rd_word}, 32'h803C);
    // R3: parity fault
    send_frame(8'h3C, 1, 0);
    drain("R3");
    chk("R3", "parity tag seen", 32'(expq.size()), 0);
    par_en = 1; par_odd = 0;
    send_frame(8'h81, 1, 0);
    chk("R3", "parity word", {16'b0, rd_word}, 32'hC481);
    drain("R3");

    // R4: framing fault then recovery
    par_en = 0;
    send_frame(8'h55, 0, 1);
    send_frame(8'h12, 0, 0);
    chk("R4", "framing word", {16'b0, rd_word}, 32'hD055);
    drain("R4");

    // R5: break and sticky flag
    send_frame(8'h00, 0, 1);
    chk("R5", "break word", {16'b0, rd_word}, 32'hD800);
    chk("R5", "brk_flag set", {31'b0, brk_flag}, 1);
    repeat (50) @(negedge clk);
    chk("R5", "brk_flag sticky", {31'b0, brk_flag}, 1);
    brk_clr = 1'b1; @(negedge clk); brk_clr = 1'b0; @(negedge clk);
    chk("R5", "brk_flag cleared", {31'b0, brk_flag}, 0);
    m_brk = 0;
    send_frame(8'h77, 0, 0);
    drain("R5");

    // R9 R8: threshold interrupt
    trig_lvl = 6'd3; rrdy_ie = 1'b1;
    send_frame(8'h01, 0, 0);
    send_frame(8'h02, 0, 0);
    chk("R9", "below level", {31'b0, rrdy_irq}, 0);
    send_frame(8'h03, 0, 0);
    chk("R9", "at level", {31'b0, rrdy_irq}, 1);
    pop_check("R9");
    chk("R9", "after pop", {31'b0, rrdy_irq}, 0);
    trig_lvl = 6'd0; @(negedge clk);
    chk("R9", "level zero acts as one", {31'b0, rrdy_irq}, 1);
    rrdy_ie = 1'b0; @(negedge clk);
    chk("R9", "disabled", {31'b0, rrdy_irq}, 0);
    drain("R8");
    trig_lvl = 6'd1;

    // R10: receiver disabled
    rx_en = 1'b0;
    send_frame(8'h99, 0, 0);
    chk("R10", "no capture", {31'b0, data_rdy}, 0);
    rx_en = 1'b1;
    repeat (20) @(negedge clk);

    // R7 R6: fill, overflow, overrun tag
    for (int i = 0; i < DEPTH + 1; i++) send_frame(8'(i + 8'h40), 0, 0);
    chk("R6", "full not lost", 32'(expq.size()), 32'(DEPTH));
    drain("R6");
    send_frame(8'hE7, 0, 0);
    chk("R7", "overrun word", {16'b0, rd_word}, 32'hE0E7);
    drain("R7");

    // random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 48; n++) begin
      word8    = $urandom_range(0, 1);
      par_en   = $urandom_range(0, 1);
      par_odd  = $urandom_range(0, 1);
      two_stop = $urandom_range(0, 1);
      send_frame(8'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
      chk("R5", "random brk_flag", {31'b0, brk_flag}, {31'b0, m_brk});
      if (m_brk) begin
        brk_clr = 1'b1; @(negedge clk); brk_clr = 1'b0; @(negedge clk);
        m_brk = 0;
      end
      if (expq.size() >= 6 || $urandom_range(0, 2) == 0) drain("R2");
    end
    drain("R6");

    finished = 1;
    summary();
    $finish;
  end

endmodule